// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one read or write transfer at a time on an external bus where the low 16 address bits and the 16 data bits share one set of pins, and the top 4 address bits share pins with a status nibble. A requester inside the chip presents a 20-bit address, a memory-or-I/O select, a direction, a byte-or-word size and write data. The sequencer then steps through an address phase, a data phase that can be stretched by the responder, and a completion state. It returns a one-cycle done pulse together with the read data.

The external side gives the framing that outside logic needs. A latch strobe marks the address phase. A data-enable strobe marks the data phase. A direction line steers bidirectional buffers, and a high-byte enable selects the byte lanes. Separate read and write strobes are provided. A hold request from another bus master is granted between transfers. A transfer already in progress runs to completion first. While the hold is granted, every bus and control output is released through its tri-state enable.

Top module: `mux_bus_seq`

## Requirements
- R1: In the address state, which is the first cycle after a request is accepted, `ale`=1, `ad_oe`=1, `ad_out` carries address bits 15..0, `addr_hi` carries address bits 19..16, and `rd_n`, `wr_n` and `den_n` are all 1.
- R2: `io_m_n` is 0 for a memory transfer and 1 for an I/O transfer, and it holds that value from the address state through the completion state.
- R3: `dt_r_n` is 1 for a write and 0 for a read throughout a transfer.
- R4: `den_n` is 0 in every data-phase cycle and only in those cycles. It is never 0 while `ale` is 1.
- R5: During the data phase a read drives `rd_n`=0 and a write drives `wr_n`=0. The two are never 0 in the same cycle. On a write, `ad_oe`=1 and `ad_out` holds the steered write data. On a read, `ad_oe`=0.
- R6: `ready` is sampled at the end of the third cycle of a transfer and of each wait cycle. Each low sample adds one wait cycle, so the data phase lasts 2 + (number of low samples) cycles. The following cycle is the completion state, in which `rsp_done`=1 for exactly one cycle.
- R7: Lane coding is given by {`bhe_n`, A0}. The value 00 means a word, 01 means the upper byte only, and 10 means the lower byte only. A byte write drives the byte `req_wdata[7:0]` on both `ad_out[15:8]` and `ad_out[7:0]`. A byte read returns the selected lane in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]`=0.
- R8: A word request with address bit 0 set is not accepted. `rsp_err`=1 and `req_accept`=0 in that same cycle, and no address state follows.
- R9: When `hold` is 1 while the sequencer is idle, no request is accepted. From the next cycle on, `hlda`=1 and `ad_oe`, `addr_oe` and `ctl_oe` are all 0.
- R10: When `hold` rises during a transfer, the transfer completes with its done pulse, and `hlda` becomes 1 in the cycle right after the completion state.
- R11: `hlda` falls in the cycle after `hold` is seen low, and `ctl_oe` returns to 1 at the same time.
- R12: While `rst_n` is 0, the outputs take their inactive values right away, even in the middle of a transfer: `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `ad_oe`=`addr_oe`=0, `hlda`=0 and `rsp_done`=0.
- R13: `rsp_rdata` holds the value of `ad_in` that was present when `ready` was sampled high to end the data phase, and it keeps that value after the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | 20 | Byte address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_wdata | input | 16 | Write data (a byte uses bits 7..0) |
| req_accept | output | 1 | Request taken this cycle |
| rsp_err | output | 1 | Request refused: odd word address |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data of the last read |
| ad_out | output | 16 | Shared address/data bus, driven value |
| ad_in | input | 16 | Shared address/data bus, sampled value |
| ad_oe | output | 1 | Drive enable for the shared bus |
| addr_hi | output | 4 | Upper address bits, or status during the data phase |
| addr_oe | output | 1 | Drive enable for `addr_hi` |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m_n | output | 1 | Space select: 1 = I/O, 0 = memory |
| dt_r_n | output | 1 | Buffer direction: 1 = transmit, 0 = receive |
| den_n | output | 1 | Data buffer enable, active low |
| bhe_n | output | 1 | Upper byte lane enable, active low |
| ctl_oe | output | 1 | Drive enable for all control strobes |
| ready | input | 1 | Responder ready; low adds wait cycles |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant to the other master |

## Verification
The hardest case to reach is a hold request that arrives while a transfer is in its data phase. The grant must wait until the done pulse, and must then come in the very next cycle, with no idle cycle in which a new request could slip in. The bench starts a read, raises `hold` in the cycle after the address state, and counts cycles from the done pulse to the grant. A second hard case is an asynchronous reset in the middle of a data phase. To reach it, the bench pulls `rst_n` low between clock edges while the read strobe is active and checks that every strobe is released before the next edge.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;

  // Bus sequencer states; order is irrelevant to decoding.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } mbus_state_e;

endpackage

// File: rtl/mbus_rst_sync.sv
`timescale 1ns/1ps
module mbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/mbus_fsm.sv
`timescale 1ns/1ps
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ready,
  input  logic        hold,
  output mbus_state_e state_o
);

  mbus_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hold)       state_d = ST_HOLD;
        else if (start) state_d = ST_T1;
      end
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ready ? ST_T4 : ST_TW;
      ST_TW:   state_d = ready ? ST_T4 : ST_TW;
      ST_T4:   state_d = hold ? ST_HOLD : ST_IDLE;
      ST_HOLD: state_d = hold ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/mbus_lane.sv
`timescale 1ns/1ps
module mbus_lane #(
  parameter int DATA_W = 16
) (
  input  logic              word,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hi_en_n
);

  localparam int HALF = DATA_W / 2;

  // Byte writes replicate onto both lanes; the strobes select the lane.
  assign bus_wdata = word ? wdata : {2{wdata[HALF-1:0]}};

  always_comb begin
    if (word)    rdata = bus_in;
    else if (a0) rdata = {{HALF{1'b0}}, bus_in[DATA_W-1:HALF]};
    else         rdata = {{HALF{1'b0}}, bus_in[HALF-1:0]};
  end

  assign hi_en_n = ~(word | a0);

endmodule

// File: rtl/mux_bus_seq.sv
`timescale 1ns/1ps
module mux_bus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int RST_SYNC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_io,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_accept,
  output logic                     rsp_err,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     addr_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_m_n,
  output logic                     dt_r_n,
  output logic                     den_n,
  output logic                     bhe_n,
  output logic                     ctl_oe,
  input  logic                     ready,
  input  logic                     hold,
  output logic                     hlda
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic        rst_s_n;
  mbus_state_e state;

  logic [ADDR_W-1:0] addr_q;
  logic              io_q, wr_q, word_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [DATA_W-1:0] lane_wdata, lane_rdata;
  logic              lane_bhe_n;

  logic is_idle, in_t1, in_data, in_t4, active, misaligned, capture;

  mbus_rst_sync #(.STAGES(RST_SYNC)) i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  // Request qualification
  assign is_idle    = (state == ST_IDLE);
  assign misaligned = req_word & req_addr[0];
  assign req_accept = is_idle & ~hold & req_valid & ~misaligned;
  assign rsp_err    = is_idle & ~hold & req_valid &  misaligned;

  mbus_fsm i_fsm (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (req_accept),
    .ready   (ready),
    .hold    (hold),
    .state_o (state)
  );

  // State decode
  assign in_t1   = (state == ST_T1);
  assign in_data = (state == ST_T2) | (state == ST_T3) | (state == ST_TW);
  assign in_t4   = (state == ST_T4);
  assign active  = in_t1 | in_data | in_t4;
  assign capture = ((state == ST_T3) | (state == ST_TW)) & ready;

  // Request and read-data registers, each with a written-out enable
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q  <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      wdata_q <= '0;
    end else if (req_accept) begin
      addr_q  <= req_addr;
      io_q    <= req_io;
      wr_q    <= req_write;
      word_q  <= req_word;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     rdata_q <= '0;
    else if (capture) rdata_q <= lane_rdata;
  end

  mbus_lane #(.DATA_W(DATA_W)) i_lane (
    .word      (word_q),
    .a0        (addr_q[0]),
    .wdata     (wdata_q),
    .bus_in    (ad_in),
    .bus_wdata (lane_wdata),
    .rdata     (lane_rdata),
    .hi_en_n   (lane_bhe_n)
  );

  // Bus outputs
  assign ale     = in_t1;
  assign ad_oe   = in_t1 | (in_data & wr_q);
  assign ad_out  = in_t1 ? addr_q[DATA_W-1:0] : lane_wdata;
  assign addr_oe = active;
  assign addr_hi = in_t1 ? addr_q[ADDR_W-1:DATA_W]
                         : {io_q, wr_q, {(HI_W-2){1'b0}}};
  assign rd_n    = ~(in_data & ~wr_q);
  assign wr_n    = ~(in_data &  wr_q);
  assign den_n   = ~in_data;
  assign io_m_n  = active ? io_q : 1'b0;
  assign dt_r_n  = active ? wr_q : 1'b1;
  assign bhe_n   = active ? lane_bhe_n : 1'b1;
  assign ctl_oe  = (state != ST_HOLD);
  assign hlda    = (state == ST_HOLD);

  assign rsp_done  = in_t4;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/mux_bus_seq_chk.sv
`timescale 1ns/1ps
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic hold,
  input logic req_accept,
  input logic rsp_err,
  input logic rsp_done,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic io_m_n,
  input logic hlda,
  input logic ad_oe,
  input logic addr_oe,
  input logic ctl_oe
);

  assert_addr_then_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !wr_n));

  assert_space_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && $past(!den_n)) |-> $stable(io_m_n));

  assert_den_not_in_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !den_n));

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_wait_extends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !ready) |=> !den_n);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_err_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !req_accept);

  assert_grant_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !addr_oe && !ctl_oe));

  assert_grant_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && hold) |=> hlda);

  assert_grant_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);

endmodule

bind mux_bus_seq mux_bus_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .hold       (hold),
  .req_accept (req_accept),
  .rsp_err    (rsp_err),
  .rsp_done   (rsp_done),
  .ale        (ale),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .den_n      (den_n),
  .io_m_n     (io_m_n),
  .hlda       (hlda),
  .ad_oe      (ad_oe),
  .addr_oe    (addr_oe),
  .ctl_oe     (ctl_oe)
);

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_io = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_accept, rsp_err, rsp_done;
  logic [15:0] rsp_rdata, ad_out;
  logic [15:0] ad_in = '0;
  logic        ad_oe, addr_oe, ale, rd_n, wr_n, io_m_n, dt_r_n, den_n, bhe_n, ctl_oe, hlda;
  logic [3:0]  addr_hi;
  logic        ready = 1'b1, hold = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_io(req_io), .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .req_accept(req_accept), .rsp_err(rsp_err), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .addr_hi(addr_hi), .addr_oe(addr_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m_n(io_m_n), .dt_r_n(dt_r_n), .den_n(den_n),
    .bhe_n(bhe_n), .ctl_oe(ctl_oe), .ready(ready), .hold(hold), .hlda(hlda)
  );

  typedef struct packed {
    logic [19:0] addr;
    logic        io;
    logic        wr;
    logic        word;
    logic [15:0] wdata;
    logic [15:0] bus_rd;
    logic [3:0]  waits;
    logic        exp_bhe_n;
    logic [15:0] exp_rdata;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{20'h12344, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 4'd0, 1'b0, 16'hBEEF},
    '{20'h0F00A, 1'b1, 1'b1, 1'b1, 16'h5A5A, 16'h0000, 4'd2, 1'b0, 16'h0000},
    '{20'hFFFF1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hC3A5, 4'd1, 1'b0, 16'h00C3},
    '{20'h80000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hC3A5, 4'd0, 1'b1, 16'h00A5},
    '{20'h00061, 1'b1, 1'b1, 1'b0, 16'h1277, 16'h0000, 4'd3, 1'b0, 16'h0000},
    '{20'h40002, 1'b0, 1'b1, 1'b0, 16'hAB3C, 16'h0000, 4'd0, 1'b1, 16'h0000},
    '{20'hFFFFE, 1'b0, 1'b1, 1'b1, 16'h0001, 16'h0000, 4'd5, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    summary();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 ale", ale, 0);
    chk("R12 rd_n/wr_n/den_n/bhe_n", {rd_n, wr_n, den_n, bhe_n}, 4'hF);
    chk("R12 oe", {ad_oe, addr_oe}, 0);
    chk("R12 hlda/done", {hlda, rsp_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R1..R7, R13
    for (int v = 0; v < NVEC; v++) begin
      automatic vec_t t = VECS[v];
      automatic logic [15:0] exp_bus = t.word ? t.wdata : {2{t.wdata[7:0]}};
      automatic int cnt = 0;
      req_valid = 1; req_addr = t.addr; req_io = t.io; req_write = t.wr;
      req_word = t.word; req_wdata = t.wdata; ready = 0;
      #1;
      chk("R8 accept legal", req_accept, 1);
      @(negedge clk);
      req_valid = 0;
      chk("R1 ale", ale, 1);
      chk("R1 ad_oe", ad_oe, 1);
      chk("R1 ad_out", ad_out, t.addr[15:0]);
      chk("R1 addr_hi", addr_hi, t.addr[19:16]);
      chk("R1 strobes idle", {rd_n, wr_n, den_n}, 3'b111);
      chk("R2 io_m_n", io_m_n, t.io);
      chk("R3 dt_r_n", dt_r_n, t.wr);
      chk("R7 bhe_n/A0", {bhe_n, ad_out[0]}, {t.exp_bhe_n, t.addr[0]});
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (rsp_done) break;
        cnt++;
        chk("R4 den_n data", den_n, 0);
        chk("R5 rd_n", rd_n, t.wr);
        chk("R5 wr_n", wr_n, !t.wr);
        chk("R2 io_m_n held", io_m_n, t.io);
        chk("R3 dt_r_n held", dt_r_n, t.wr);
        chk("R7 bhe_n held", bhe_n, t.exp_bhe_n);
        chk("R5 ad_oe", ad_oe, t.wr);
        if (t.wr) chk("R7 write lanes", ad_out, exp_bus);
        ad_in = t.bus_rd;
        ready = (cnt >= 2 + int'(t.waits));
      end
      chk("R6 data cycles", cnt, 2 + int'(t.waits));
      chk("R6 done with strobes off", {rsp_done, rd_n, wr_n, den_n}, 4'hF);
      chk("R2 io_m_n in T4", io_m_n, t.io);
      if (!t.wr) chk("R13/R7 read data", rsp_rdata, t.exp_rdata);
      ad_in = 16'hFFFF; ready = 1;
      @(negedge clk);
      chk("R6 done single", rsp_done, 0);
      if (!t.wr) chk("R13 read data kept", rsp_rdata, t.exp_rdata);
    end

    // R8: odd word address refused
    req_valid = 1; req_addr = 20'h00123; req_word = 1; req_write = 0; req_io = 0;
    #1;
    chk("R8 err", rsp_err, 1);
    chk("R8 not accepted", req_accept, 0);
    @(negedge clk);
    req_valid = 0;
    chk("R8 no address state", {ale, addr_oe}, 0);

    // R9/R11: hold while idle, request pending
    hold = 1; req_valid = 1; req_addr = 20'h00200;
    #1;
    chk("R9 no accept in hold", req_accept, 0);
    @(negedge clk);
    chk("R9 hlda", hlda, 1);
    chk("R9 floated", {ad_oe, addr_oe, ctl_oe}, 0);
    chk("R9 still no accept", req_accept, 0);
    req_valid = 0;
    @(negedge clk);
    chk("R11 hlda kept", hlda, 1);
    hold = 0;
    @(negedge clk);
    chk("R11 hlda dropped", hlda, 0);
    chk("R11 ctl_oe back", ctl_oe, 1);

    // R10: hold raised during a read
    req_valid = 1; req_addr = 20'h30000; req_word = 1; req_write = 0; ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 address state", ale, 1);
    @(negedge clk);
    hold = 1;
    @(negedge clk);
    chk("R10 no grant mid-cycle", hlda, 0);
    @(negedge clk);
    chk("R10 done", rsp_done, 1);
    chk("R10 no grant at done", hlda, 0);
    @(negedge clk);
    chk("R10 grant after done", hlda, 1);
    hold = 0;
    @(negedge clk);
    chk("R11 release", hlda, 0);

    // R12: reset during data phase
    req_valid = 1; req_addr = 20'h55554; req_word = 1; req_write = 0; ready = 0;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk("R5 read strobe before reset", rd_n, 0);
    rst_n = 0;
    #1;
    chk("R12 strobes released", {rd_n, wr_n, den_n, bhe_n, ale}, 5'b11110);
    chk("R12 outputs floated", {ad_oe, addr_oe, rsp_done}, 0);
    @(negedge clk);
    rst_n = 1; ready = 1;
    repeat (4) @(negedge clk);
    chk("R12 idle after release", {ale, den_n, ctl_oe, hlda}, 4'b0110);

    summary();
  end

endmodule